// File: doc/BRIEF.md
# Four-Channel Peripheral DMA Sequencer

This block keeps the addressing state for four independent peripheral DMA channels. Software programs each channel through a small memory-mapped register port: a start address, a control word and a unit count. The channel stays idle until it receives an explicit start command. While it runs, each request pulse from the peripheral side consumes one unit. The block then emits a one-cycle address strobe that carries the current address and the transfer direction, advances the address by the unit size and decrements the remaining count.

Each channel reports progress in two stages. A half-way flag sets when the remaining count falls to half of the programmed count, and a done flag sets when the count runs out. A single shared interrupt line is asserted while any channel holds a flag whose interrupt enable is set. Channels are started, stopped and have their flags cleared only through a write-only command register. Channel 0 also accepts a freeze toggle and a single-unit skip. The data path, the peripheral selection and memory itself are outside this block, which only supplies addresses and direction.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, no strobe is active and the interrupt output is low.
- R2: Channel n's registers start at byte address 0x20*n. The registers are: start address at +0x00, control at +0x04, and unit count at +0x08, of which the low 16 bits are kept. The following registers read back as well: current address at +0x0C and remaining count at +0x10. These two are read-only, and writes to them are ignored. The command register is at +0x14 and reads as 0. The global status word is at 0x80.
- R3: Writing a channel's start address, control and count does not start it. Requests to an idle channel produce no strobe and leave its counters unchanged.
- R4: Command code 4 (start) copies the start address into the current address and the unit count into the remaining count. It then runs the channel if the count is non-zero. With a zero count, the channel stays idle.
- R5: A request pulse on a running channel produces a strobe in the following cycle. The strobe carries the current address and the direction taken from control bit 29. The address then advances by 1, 2 or 4 for control bits 23:22 equal to 0, 1 or 2 (a value of 3 also steps by 4), and the remaining count drops by 1.
- R6: The half-way flag (status bit 4n+1) sets when the remaining count reaches floor(count/2). The done flag (status bit 4n) sets when the remaining count reaches 0. At that point the channel stops, and later requests produce no strobe.
- R7: When control bit 18 (reload) is set, a channel that finishes sets its done flag and then reloads its current address and remaining count from the programmed values. It keeps running.
- R8: Command code 5 (stop) halts a channel. It keeps its current address and remaining count, and later requests produce no strobe.
- R9: Command code 6 clears only the half-way flag. Command code 7 clears both flags.
- R10: The interrupt output is high exactly while some channel has its done flag set together with control bit 16, or its half-way flag set together with control bit 17.
- R11: On channel 0, command code 2 toggles a freeze. A frozen channel consumes no requests: it produces no strobe and its count stays unchanged. A start command releases the freeze.
- R12: On channel 0, command code 3 consumes one unit of a running, unfrozen channel without a strobe. The address advances, the count drops, and the flags update exactly as for a request.
- R13: Command codes 2 and 3 have no effect on channels 1 to 3.
- R14: If a command is written to a channel in the same cycle as that channel's request, the command takes effect and the request is dropped. No strobe is produced and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| dreq | input | 4 | Per-channel request pulses, one unit each |
| strb | output | 4 | Per-channel address strobes |
| strb_addr | output | 128 | Strobe addresses, channel n in bits 32n+31:32n |
| strb_dir | output | 4 | Per-channel direction that goes with each strobe |
| irq | output | 1 | Shared completion interrupt |

## Verification
A table drives one channel per row, and the rows cover every unit-size code, both direction values, and pulse counts that stop short of half-way, land exactly on it, or run to the end. This separates a wrong address step from a wrong half-way threshold or a premature done flag. Directed runs then compare reload against stop-at-end, and stop against freeze. The freeze and skip codes are sent to both channel 0 and channel 1, and a command is made to collide with a request. A wrong priority or a wrong channel restriction therefore shows up as an unexpected strobe or count.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [3:0] {
        CMD_FREEZE = 4'd2,
        CMD_SKIP   = 4'd3,
        CMD_START  = 4'd4,
        CMD_STOP   = 4'd5,
        CMD_CLR_H  = 4'd6,
        CMD_CLR_HW = 4'd7
    } dmac_cmd_e;

    localparam logic [4:0] OFS_BASE  = 5'h00;
    localparam logic [4:0] OFS_CTRL  = 5'h04;
    localparam logic [4:0] OFS_COUNT = 5'h08;
    localparam logic [4:0] OFS_CADDR = 5'h0C;
    localparam logic [4:0] OFS_CCNT  = 5'h10;
    localparam logic [4:0] OFS_CMD   = 5'h14;

    localparam int CTL_DIR    = 29;
    localparam int CTL_SIZE   = 22;
    localparam int CTL_RELOAD = 18;
    localparam int CTL_HIE    = 17;
    localparam int CTL_DIE    = 16;

    typedef struct packed {
        logic done;
        logic half;
    } dmac_flags_t;

    function automatic logic [2:0] unit_step(input logic [1:0] size_code);
        case (size_code)
            2'd0:    unit_step = 3'd1;
            2'd1:    unit_step = 3'd2;
            default: unit_step = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter bit HAS_EXTRA = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [4:0]    wr_off,
    input  logic [31:0]   wdata,
    input  logic          dreq,
    output logic [AW-1:0] base_o,
    output logic [31:0]   ctrl_o,
    output logic [CW-1:0] count_o,
    output logic [AW-1:0] caddr_o,
    output logic [CW-1:0] ccnt_o,
    output dmac_flags_t   flags_o,
    output logic          held_o,
    output logic          strb_o,
    output logic [AW-1:0] strb_addr_o,
    output logic          strb_dir_o
);
    logic [AW-1:0] base_q, caddr_q, saddr_q;
    logic [31:0]   ctrl_q;
    logic [CW-1:0] count_q, ccnt_q, thr_q, nxt_cnt;
    logic          run_q, strb_q, sdir_q;
    dmac_flags_t   flg_q;
    logic          cmd_wr, take_req, take_skip, consume, hold_now;
    logic [3:0]    code;

    assign cmd_wr    = wr_en && (wr_off == OFS_CMD);
    assign code      = wdata[3:0];
    assign take_req  = !cmd_wr && dreq && run_q && !hold_now;
    assign take_skip = HAS_EXTRA && cmd_wr && (code == CMD_SKIP) && run_q && !hold_now;
    assign consume   = take_req || take_skip;
    assign nxt_cnt   = ccnt_q - CW'(1);

    generate
        if (HAS_EXTRA) begin : g_freeze
            logic hold_q;
            always_ff @(posedge clk) begin
                if (rst)
                    hold_q <= 1'b0;
                else if (cmd_wr && code == CMD_START)
                    hold_q <= 1'b0;
                else if (cmd_wr && code == CMD_FREEZE)
                    hold_q <= !hold_q;
            end
            assign hold_now = hold_q;
        end else begin : g_nofreeze
            assign hold_now = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            ctrl_q  <= '0;
            count_q <= '0;
            caddr_q <= '0;
            ccnt_q  <= '0;
            thr_q   <= '0;
            run_q   <= 1'b0;
            flg_q   <= '0;
            strb_q  <= 1'b0;
            saddr_q <= '0;
            sdir_q  <= 1'b0;
        end else begin
            strb_q <= take_req;
            if (take_req) begin
                saddr_q <= caddr_q;
                sdir_q  <= ctrl_q[CTL_DIR];
            end
            if (wr_en && wr_off == OFS_BASE)  base_q  <= wdata[AW-1:0];
            if (wr_en && wr_off == OFS_CTRL)  ctrl_q  <= wdata;
            if (wr_en && wr_off == OFS_COUNT) count_q <= wdata[CW-1:0];
            if (cmd_wr) begin
                case (code)
                    CMD_START: begin
                        caddr_q <= base_q;
                        ccnt_q  <= count_q;
                        thr_q   <= count_q >> 1;
                        run_q   <= (count_q != '0);
                    end
                    CMD_STOP:   run_q      <= 1'b0;
                    CMD_CLR_H:  flg_q.half <= 1'b0;
                    CMD_CLR_HW: flg_q      <= '0;
                    default: ;
                endcase
            end
            if (consume) begin
                caddr_q <= caddr_q + AW'(unit_step(ctrl_q[CTL_SIZE+:2]));
                ccnt_q  <= nxt_cnt;
                if (nxt_cnt == thr_q) flg_q.half <= 1'b1;
                if (nxt_cnt == '0) begin
                    flg_q.done <= 1'b1;
                    if (ctrl_q[CTL_RELOAD]) begin
                        caddr_q <= base_q;
                        ccnt_q  <= count_q;
                        thr_q   <= count_q >> 1;
                        run_q   <= (count_q != '0);
                    end else begin
                        run_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign base_o      = base_q;
    assign ctrl_o      = ctrl_q;
    assign count_o     = count_q;
    assign caddr_o     = caddr_q;
    assign ccnt_o      = ccnt_q;
    assign flags_o     = flg_q;
    assign held_o      = hold_now;
    assign strb_o      = strb_q;
    assign strb_addr_o = saddr_q;
    assign strb_dir_o  = sdir_q;
endmodule

// File: rtl/dmac_readmux.sv
module dmac_readmux
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 8
) (
    input  logic [RAW-1:0] rd_addr,
    input  logic [AW-1:0]  base  [NCH],
    input  logic [31:0]    ctrl  [NCH],
    input  logic [CW-1:0]  count [NCH],
    input  logic [AW-1:0]  caddr [NCH],
    input  logic [CW-1:0]  ccnt  [NCH],
    input  dmac_flags_t    flags [NCH],
    output logic [31:0]    rdata,
    output logic           irq
);
    localparam int CIW       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int STAT_ADDR = NCH * 32;

    logic [RAW-6:0] chi;
    logic [CIW-1:0] ci;
    logic [4:0]     ofs;
    logic [31:0]    status;

    assign chi = rd_addr[RAW-1:5];
    assign ci  = chi[CIW-1:0];
    assign ofs = rd_addr[4:0];

    always_comb begin
        status = '0;
        irq    = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            status[4*i]   = flags[i].done;
            status[4*i+1] = flags[i].half;
            irq = irq | (flags[i].done & ctrl[i][CTL_DIE])
                      | (flags[i].half & ctrl[i][CTL_HIE]);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_addr == RAW'(STAT_ADDR)) begin
            rdata = status;
        end else if (int'(chi) < NCH) begin
            case (ofs)
                OFS_BASE:  rdata = 32'(base[ci]);
                OFS_CTRL:  rdata = ctrl[ci];
                OFS_COUNT: rdata = 32'(count[ci]);
                OFS_CADDR: rdata = 32'(caddr[ci]);
                OFS_CCNT:  rdata = 32'(ccnt[ci]);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [NCH-1:0]   dreq,
    output logic [NCH-1:0]   strb,
    output logic [NCH*AW-1:0] strb_addr,
    output logic [NCH-1:0]   strb_dir,
    output logic             irq
);
    logic [AW-1:0] base_a  [NCH];
    logic [31:0]   ctrl_a  [NCH];
    logic [CW-1:0] count_a [NCH];
    logic [AW-1:0] caddr_a [NCH];
    logic [CW-1:0] ccnt_a  [NCH];
    dmac_flags_t   flags_a [NCH];
    logic [NCH-1:0] held_v, flag_w, flag_h;
    logic           held0;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic sel;
            assign sel = reg_wr && (reg_addr[RAW-1:5] == (RAW-5)'(i));
            dmac_channel #(
                .AW(AW), .CW(CW), .HAS_EXTRA(i == 0)
            ) u_ch (
                .clk(clk), .rst(rst),
                .wr_en(sel), .wr_off(reg_addr[4:0]), .wdata(reg_wdata),
                .dreq(dreq[i]),
                .base_o(base_a[i]), .ctrl_o(ctrl_a[i]), .count_o(count_a[i]),
                .caddr_o(caddr_a[i]), .ccnt_o(ccnt_a[i]), .flags_o(flags_a[i]),
                .held_o(held_v[i]), .strb_o(strb[i]),
                .strb_addr_o(strb_addr[i*AW +: AW]), .strb_dir_o(strb_dir[i])
            );
            assign flag_w[i] = flags_a[i].done;
            assign flag_h[i] = flags_a[i].half;
        end
    endgenerate

    assign held0 = held_v[0];

    dmac_readmux #(.NCH(NCH), .AW(AW), .CW(CW), .RAW(RAW)) u_rd (
        .rd_addr(reg_addr),
        .base(base_a), .ctrl(ctrl_a), .count(count_a),
        .caddr(caddr_a), .ccnt(ccnt_a), .flags(flags_a),
        .rdata(reg_rdata), .irq(irq)
    );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] strb,
    input logic           irq,
    input logic [NCH-1:0] flag_w,
    input logic [NCH-1:0] flag_h,
    input logic           held0
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (strb == '0) && !irq);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flag_w | flag_h) != '0));

    // R11
    freeze_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (held0 && dreq[0]) |=> !strb[0]);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_a
            // R5
            strobe_from_req_chk: assert property (@(posedge clk) disable iff (rst)
                strb[i] |-> $past(dreq[i]));
            if (i > 0) begin : g_nz
                // R6
                done_from_req_chk: assert property (@(posedge clk) disable iff (rst)
                    $rose(flag_w[i]) |-> $past(dreq[i]));
            end
        end
    endgenerate
endmodule

bind dma_chan_ctrl dmac_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .dreq(dreq), .strb(strb), .irq(irq),
    .flag_w(flag_w), .flag_h(flag_h), .held0(held0)
);

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [3:0]   dreq = '0;
    logic [3:0]   strb;
    logic [127:0] strb_addr;
    logic [3:0]   strb_dir;
    logic         irq;
    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    dma_chan_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .strb(strb), .strb_addr(strb_addr), .strb_dir(strb_dir), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  dsz;
        logic [31:0] base;
        logic [15:0] cnt;
        logic [7:0]  np;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{ch: 2'd0, dsz: 2'd0, base: 32'h1000, cnt: 16'd5, np: 8'd2},
        '{ch: 2'd1, dsz: 2'd1, base: 32'h2000, cnt: 16'd6, np: 8'd3},
        '{ch: 2'd2, dsz: 2'd2, base: 32'h3000, cnt: 16'd4, np: 8'd4},
        '{ch: 2'd3, dsz: 2'd3, base: 32'h4000, cnt: 16'd3, np: 8'd2}
    };

    function automatic logic [7:0] ra(input int ch, input int ofs);
        return 8'(ch * 32 + ofs);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int ch, output logic s, output logic [31:0] a, output logic dir);
        @(negedge clk);
        dreq[ch] = 1'b1;
        @(negedge clk);
        dreq[ch] = 1'b0;
        s = strb[ch];
        a = strb_addr[ch*32 +: 32];
        dir = strb_dir[ch];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic s, dir;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(ra(0, 0), d);      chk("R1 base0", d, 0);
        rd(ra(3, 'h10), d);   chk("R1 ccnt3", d, 0);
        rd(8'h80, d);         chk("R1 status", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 strb", {28'b0, strb}, 0);

        // R2 register map
        wr(ra(2, 'h00), 32'hABCD0000); rd(ra(2, 'h00), d); chk("R2 base", d, 32'hABCD0000);
        wr(ra(2, 'h04), 32'h12340000); rd(ra(2, 'h04), d); chk("R2 ctrl", d, 32'h12340000);
        wr(ra(2, 'h08), 32'h00010009); rd(ra(2, 'h08), d); chk("R2 count", d, 32'h9);
        rd(ra(2, 'h14), d); chk("R2 cmd reads 0", d, 0);
        wr(ra(2, 'h0C), 32'h55); rd(ra(2, 'h0C), d); chk("R2 caddr read-only", d, 0);
        wr(ra(2, 'h04), 32'h0);

        // R3 configured but not started
        wr(ra(1, 'h00), 32'h500); wr(ra(1, 'h08), 3);
        pulse(1, s, a, dir); chk("R3 no strobe", {31'b0, s}, 0);
        rd(ra(1, 'h10), d); chk("R3 count idle", d, 0);

        // Table: R4 R5 R6
        for (int r = 0; r < 4; r++) begin
            vec_t v;
            int ch;
            int step;
            v = VEC[r];
            ch = int'(v.ch);
            step = (v.dsz == 0) ? 1 : (v.dsz == 1) ? 2 : 4;
            wr(ra(ch, 'h00), v.base);
            wr(ra(ch, 'h04), (32'(ch & 1) << 29) | (32'(v.dsz) << 22));
            wr(ra(ch, 'h08), 32'(v.cnt));
            wr(ra(ch, 'h14), 7);
            wr(ra(ch, 'h14), 4);
            rd(ra(ch, 'h0C), d); chk("R4 caddr load", d, v.base);
            rd(ra(ch, 'h10), d); chk("R4 ccnt load", d, 32'(v.cnt));
            for (int k = 0; k < int'(v.np); k++) begin
                pulse(ch, s, a, dir);
                chk("R5 strobe", {31'b0, s}, 1);
                chk("R5 addr", a, v.base + 32'(k * step));
                chk("R5 dir", {31'b0, dir}, 32'(ch & 1));
            end
            rd(ra(ch, 'h0C), d); chk("R5 caddr", d, v.base + 32'(int'(v.np) * step));
            rd(ra(ch, 'h10), d); chk("R5 ccnt", d, 32'(v.cnt) - 32'(v.np));
            rd(8'h80, d);
            chk("R6 half", {31'b0, d[4*ch+1]},
                32'((32'(v.cnt) - 32'(v.np)) <= 32'(v.cnt >> 1)));
            chk("R6 done", {31'b0, d[4*ch]}, 32'(v.np == v.cnt[7:0]));
        end
        // R6 stopped after finishing
        pulse(2, s, a, dir); chk("R6 stopped", {31'b0, s}, 0);

        // R4 zero count stays idle
        wr(ra(3, 'h08), 0); wr(ra(3, 'h14), 4);
        pulse(3, s, a, dir); chk("R4 zero count", {31'b0, s}, 0);

        // R7 reload
        wr(ra(1, 'h00), 32'h800); wr(ra(1, 'h04), 32'h1 << 18); wr(ra(1, 'h08), 2);
        wr(ra(1, 'h14), 7); wr(ra(1, 'h14), 4);
        pulse(1, s, a, dir); pulse(1, s, a, dir);
        pulse(1, s, a, dir);
        chk("R7 strobe after reload", {31'b0, s}, 1);
        chk("R7 addr reloaded", a, 32'h800);
        rd(8'h80, d); chk("R7 done set", {31'b0, d[4]}, 1);

        // R8 stop
        wr(ra(1, 'h14), 5);
        pulse(1, s, a, dir); chk("R8 no strobe", {31'b0, s}, 0);
        rd(ra(1, 'h10), d); chk("R8 count kept", d, 1);
        rd(ra(1, 'h0C), d); chk("R8 addr kept", d, 32'h801);

        // R9 flag clears on channel 2 (both flags set by table)
        wr(ra(2, 'h14), 6);
        rd(8'h80, d); chk("R9 half cleared", {31'b0, d[9]}, 0);
        chk("R9 done kept", {31'b0, d[8]}, 1);
        wr(ra(2, 'h14), 7);
        rd(8'h80, d); chk("R9 done cleared", {31'b0, d[8]}, 0);

        // R10 interrupt gating
        @(negedge clk); chk("R10 flags without enables", {31'b0, irq}, 0);
        wr(ra(3, 'h04), (32'h1 << 17) | (32'h1 << 29) | (32'h3 << 22));
        @(negedge clk); chk("R10 half enabled", {31'b0, irq}, 1);
        wr(ra(3, 'h14), 7);
        @(negedge clk); chk("R10 cleared", {31'b0, irq}, 0);
        wr(ra(2, 'h04), 32'h1 << 16); wr(ra(2, 'h08), 1); wr(ra(2, 'h14), 4);
        pulse(2, s, a, dir);
        @(negedge clk); chk("R10 done enabled", {31'b0, irq}, 1);
        wr(ra(2, 'h14), 7);
        @(negedge clk); chk("R10 done cleared", {31'b0, irq}, 0);

        // R11 freeze on channel 0
        wr(ra(0, 'h00), 32'h100); wr(ra(0, 'h04), 0); wr(ra(0, 'h08), 4);
        wr(ra(0, 'h14), 7); wr(ra(0, 'h14), 4);
        wr(ra(0, 'h14), 2);
        pulse(0, s, a, dir); chk("R11 frozen no strobe", {31'b0, s}, 0);
        rd(ra(0, 'h10), d); chk("R11 frozen count", d, 4);
        wr(ra(0, 'h14), 2);
        pulse(0, s, a, dir); chk("R11 released strobe", {31'b0, s}, 1);
        chk("R11 released addr", a, 32'h100);

        // R12 skip on channel 0
        wr(ra(0, 'h14), 3);
        chk("R12 skip no strobe", {31'b0, strb[0]}, 0);
        rd(ra(0, 'h10), d); chk("R12 skip count", d, 2);
        rd(ra(0, 'h0C), d); chk("R12 skip addr", d, 32'h102);
        rd(8'h80, d); chk("R12 skip half flag", {31'b0, d[1]}, 1);

        // R13 freeze/skip ignored on channel 1
        wr(ra(1, 'h00), 32'h900); wr(ra(1, 'h04), 0); wr(ra(1, 'h08), 4);
        wr(ra(1, 'h14), 4);
        wr(ra(1, 'h14), 2);
        pulse(1, s, a, dir); chk("R13 freeze ignored", {31'b0, s}, 1);
        wr(ra(1, 'h14), 3);
        rd(ra(1, 'h10), d); chk("R13 skip ignored", d, 3);

        // R14 command and request in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ra(1, 'h14); reg_wdata = 6; dreq[1] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; dreq[1] = 1'b0;
        chk("R14 request dropped", {31'b0, strb[1]}, 0);
        rd(ra(1, 'h10), d); chk("R14 count unchanged", d, 3);

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule